// File: doc/BRIEF.md
# Triggered Fan Tachometer Unit

This block measures the rotation speed of a fan on one of up to sixteen tachometer inputs at a time. Software starts a measurement by moving a channel's trigger bit from 0 to 1. The block then waits for a qualifying edge on that channel's tach input and counts divided-clock ticks until the next qualifying edge. The count and a done flag are posted in one 32-bit result word. Converting the count to RPM is left to software. Software must double the divisor when both edges are counted, because the count then covers half a tach period.

Each channel has an enable bit and a 3-bit source that picks one of eight shared type configurations. Each type configuration holds a type enable, an edge mode, a tach clock divider exponent and a measurement unit that bounds how long the block waits. The measurement is one-shot. When it finishes, the result holds still until the next trigger.

Top module: `tach_meter`

## Requirements
- R1: While reset is asserted and right after it, the result word is all zeros.
- R2: A measurement starts only when a trigger bit goes from 0 to 1. If several bits rise together, the lowest channel index wins. The done flag and the count read 0 from the cycle after the start. A trigger bit that stays at 1 starts nothing, and the result stays unchanged while no measurement runs.
- R3: The count is the number of tach-clock ticks between two consecutive qualifying edges. The tach clock period is `4 << (2*div)` input clock cycles, where div is the type word's bits 3:1. For edges P clock cycles apart, the count is floor((P-1) / (4 << (2*div))).
- R4: The edge mode sits in type word bits 5:4. The encodings are 00 = falling edges, 01 = rising edges and 10 = both edges. With 11 no edge qualifies.
- R5: The result word has the done flag at bit 31 and the count in bits 19:0. Bits 30:20 read zero.
- R6: A channel's source bits 1:0 are taken from `src_lo[2*ch+1:2*ch]` and its bit 2 from `src_ext[ch]`. The source selects the type word at `type_cfg[22*src +: 22]`.
- R7: A start on a channel whose `chan_en` bit is 0, or whose type word has enable bit 0 clear, sets done in the next cycle with a count of 0.
- R8: The measurement unit sits in type word bits 21:6. A phase times out when its running tick count reaches a nonzero unit, or reaches all ones, before the next qualifying edge. A phase is the wait for the first edge or the wait for the second. On a timeout, done is set with a count of 0.
- R9: Each tach input passes through a two-flop synchronizer before edge detection. Edges that are detected before the start cycle are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tach_i | input | NCH | Raw tachometer inputs |
| chan_en | input | NCH | Per-channel enable |
| src_lo | input | 2*NCH | Source bits 1:0, two per channel |
| src_ext | input | NCH | Source bit 2, one per channel |
| type_cfg | input | 22*2^SRC_W | Packed type configuration words |
| trig | input | NCH | Trigger bits, one per channel |
| result_o | output | 32 | Done flag and measured count |

## Verification
The situations hardest to reach from the ports are the timeouts. One is a measurement whose second edge never arrives in time. The other is a reserved edge mode on which no edge ever qualifies. The bench reaches both by routing channels through their sources to types with a small measurement unit or the reserved mode, while long tach periods still drive their inputs. Every channel is swept across several high/low pulse shapes. Before each trigger the input is lowered, so a falling edge lands just before the start and must not be counted. A multi-bit trigger and a trigger that stays set finish the stimulus.

// File: rtl/tach_meter_pkg.sv
package tach_meter_pkg;
  localparam int UNIT_W = 16;
  localparam int DIV_W  = 3;
  localparam int CFG_W  = UNIT_W + 2 + DIV_W + 1;

  typedef enum logic [1:0] {
    MODE_FALL = 2'b00,
    MODE_RISE = 2'b01,
    MODE_BOTH = 2'b10,
    MODE_NONE = 2'b11
  } edge_mode_e;

  typedef struct packed {
    logic [UNIT_W-1:0] unit;
    edge_mode_e        mode;
    logic [DIV_W-1:0]  div;
    logic              en;
  } type_cfg_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ARM  = 2'b01,
    ST_MEAS = 2'b10
  } meas_st_e;
endpackage

// File: rtl/tach_edge.sv
module tach_edge #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tach_i,
  output logic [NCH-1:0] rise_o,
  output logic [NCH-1:0] fall_o
);
  // per channel: [0] first sync flop, [1] second sync flop, [2] previous value
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [2:0] sh_q;
    logic [2:0] sh_d;

    always_comb sh_d = {sh_q[1:0], tach_i[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= 3'b000;
      else        sh_q <= sh_d;
    end

    assign rise_o[g] = sh_q[1] & ~sh_q[2];
    assign fall_o[g] = ~sh_q[1] & sh_q[2];
  end
endmodule

// File: rtl/tach_presc.sv
module tach_presc
  import tach_meter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int PRE_W = 2 * (2 ** DIV_W) + 1;

  logic [PRE_W-1:0] pre_q, pre_d, lim_m1;

  always_comb begin
    lim_m1 = (PRE_W'(1) << (2 + 2 * int'(div_i))) - PRE_W'(1);
    tick_o = run_i && !clr_i && (pre_q >= lim_m1);
    if (clr_i)       pre_d = '0;
    else if (tick_o) pre_d = '0;
    else if (run_i)  pre_d = pre_q + PRE_W'(1);
    else             pre_d = pre_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  AST_TICK_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (pre_q == '0)); // R3
endmodule

// File: rtl/tach_meter.sv
module tach_meter
  import tach_meter_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int SRC_W = 3,
  parameter int CNT_W = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NCH-1:0]                tach_i,
  input  logic [NCH-1:0]                chan_en,
  input  logic [2*NCH-1:0]              src_lo,
  input  logic [NCH-1:0]                src_ext,
  input  logic [CFG_W*(2**SRC_W)-1:0]   type_cfg,
  input  logic [NCH-1:0]                trig,
  output logic [31:0]                   result_o
);
  localparam int NTYPE = 2 ** SRC_W;
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;

  type_cfg_t cfg_arr [NTYPE];
  for (genvar t = 0; t < NTYPE; t++) begin : g_cfg
    assign cfg_arr[t] = type_cfg_t'(type_cfg[t*CFG_W +: CFG_W]);
  end

  logic [NCH-1:0] rise, fall;
  tach_edge #(.NCH(NCH)) i_edge (
    .clk(clk), .rst_n(rst_n), .tach_i(tach_i), .rise_o(rise), .fall_o(fall)
  );

  meas_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, val_q, val_d, cnt_inc;
  logic              done_q, done_d;
  logic [CH_W-1:0]   chan_q, chan_d, sel;
  logic [NCH-1:0]    trig_q, rose;
  logic [SRC_W-1:0]  src_cur, src_sel;
  type_cfg_t         cfg_cur, cfg_sel;
  logic              start, ok_sel, qual, tick, tmo, pclr;

  // start detection and lowest-index selection
  always_comb begin
    rose  = trig & ~trig_q;
    start = |rose;
    sel   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (rose[i]) sel = CH_W'(i);
    end
    src_sel = {src_ext[sel], src_lo[{sel, 1'b0} +: 2]};
    cfg_sel = cfg_arr[src_sel];
    ok_sel  = chan_en[sel] && cfg_sel.en;
    src_cur = {src_ext[chan_q], src_lo[{chan_q, 1'b0} +: 2]};
    cfg_cur = cfg_arr[src_cur];
  end

  always_comb begin
    unique case (cfg_cur.mode)
      MODE_FALL: qual = fall[chan_q];
      MODE_RISE: qual = rise[chan_q];
      MODE_BOTH: qual = rise[chan_q] | fall[chan_q];
      default:   qual = 1'b0;
    endcase
  end

  tach_presc i_presc (
    .clk(clk), .rst_n(rst_n), .clr_i(pclr), .run_i(st_q != ST_IDLE),
    .div_i(cfg_cur.div), .tick_o(tick)
  );

  always_comb begin
    cnt_inc = cnt_q + CNT_W'(1);
    tmo = tick && (((cfg_cur.unit != '0) && (cnt_inc == CNT_W'(cfg_cur.unit)))
                   || (&cnt_inc));
  end

  // next-state
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    val_d  = val_q;
    done_d = done_q;
    chan_d = chan_q;
    pclr   = 1'b0;
    if (start) begin
      chan_d = sel;
      cnt_d  = '0;
      val_d  = '0;
      pclr   = 1'b1;
      if (ok_sel) begin
        done_d = 1'b0;
        st_d   = ST_ARM;
      end else begin
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
    end else begin
      unique case (st_q)
        ST_ARM: begin
          if (qual) begin
            st_d  = ST_MEAS;
            cnt_d = '0;
            pclr  = 1'b1;
          end else if (tmo) begin
            done_d = 1'b1;
            val_d  = '0;
            st_d   = ST_IDLE;
          end else if (tick) begin
            cnt_d = cnt_inc;
          end
        end
        ST_MEAS: begin
          if (qual) begin
            done_d = 1'b1;
            val_d  = cnt_q;
            st_d   = ST_IDLE;
          end else if (tmo) begin
            done_d = 1'b1;
            val_d  = '0;
            st_d   = ST_IDLE;
          end else if (tick) begin
            cnt_d = cnt_inc;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      val_q  <= '0;
      done_q <= 1'b0;
      chan_q <= '0;
      trig_q <= '0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      val_q  <= val_d;
      done_q <= done_d;
      chan_q <= chan_d;
      trig_q <= trig;
    end
  end

  assign result_o = {done_q, {(31 - CNT_W){1'b0}}, val_q};

  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ok_sel) |=> (result_o == 32'h0)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && st_q == ST_IDLE) |=> $stable(result_o)); // R2
  AST_MEAS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && st_q == ST_MEAS && qual) |=> (done_q && val_q == $past(cnt_q))); // R3
  AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !ok_sel) |=> (result_o == 32'h8000_0000)); // R7
  AST_TMO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && st_q != ST_IDLE && !qual && tmo) |=> (done_q && val_q == '0)); // R8
endmodule

// File: tb/test_tach_meter.sv
`timescale 1ns/1ps
module test_tach_meter;
  localparam int NCH = 16;
  localparam int CW  = 22;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    tach, chan_en, src_ext, trig;
  logic [2*NCH-1:0]  src_lo;
  logic [8*CW-1:0]   type_cfg;
  logic [31:0]       result;

  int n_chk = 0;
  int n_err = 0;

  int t_en   [8] = '{1, 1, 1, 1, 0, 1, 1, 1};
  int t_div  [8] = '{0, 1, 0, 0, 0, 2, 0, 1};
  int t_mode [8] = '{1, 0, 2, 3, 1, 1, 1, 2};
  int t_unit [8] = '{1000, 1000, 1000, 8, 1000, 1000, 6, 1000};

  always #4 clk = ~clk;

  tach_meter i_tach_meter (
    .clk(clk), .rst_n(rst_n), .tach_i(tach), .chan_en(chan_en),
    .src_lo(src_lo), .src_ext(src_ext), .type_cfg(type_cfg),
    .trig(trig), .result_o(result)
  );

  function automatic int src_of(input int ch);
    return (ch + 5) % 8;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [NCH-1:0] mask, input int ch, input int hi, input int lo);
    int t, p, lim, c;
    bit ok;
    string tag;
    t  = src_of(ch);
    ok = (chan_en[ch] == 1'b1) && (t_en[t] != 0);
    lim = 4 << (2 * t_div[t]);
    c = 0;
    if (!ok) tag = "R7";
    else if (t_mode[t] == 3) tag = "R4 R8";
    else begin
      p = (t_mode[t] == 2) ? hi : hi + lo;
      c = (p - 1) / lim;
      if (c >= t_unit[t]) begin
        c = 0;
        tag = "R8";
      end else tag = "R3 R4 R5 R6 R9";
    end
    @(negedge clk);
    tach = '0;
    trig = '0;
    repeat (4) @(negedge clk);
    trig = mask;
    @(negedge clk);
    check(ok ? "R2 start clears" : "R7 immediate", result, ok ? 32'h0 : 32'h8000_0000);
    repeat (2) @(negedge clk);
    tach[ch] = 1'b1; repeat (hi) @(negedge clk);
    tach[ch] = 1'b0; repeat (lo) @(negedge clk);
    tach[ch] = 1'b1; repeat (hi) @(negedge clk);
    tach[ch] = 1'b0; repeat (lo) @(negedge clk);
    tach[ch] = 1'b1;
    for (int k = 0; k < 3000 && !result[31]; k++) @(negedge clk);
    check(tag, result, {1'b1, 11'b0, 20'(c)});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0;
    tach = '0;
    trig = '0;
    chan_en = 16'hFFFF & ~(16'h1 << 9) & ~(16'h1 << 14);
    for (int ch = 0; ch < NCH; ch++) begin
      logic [2:0] s;
      s = 3'(src_of(ch));
      src_lo[2*ch +: 2] = s[1:0];
      src_ext[ch] = s[2];
    end
    for (int t = 0; t < 8; t++)
      type_cfg[t*CW +: CW] = {16'(t_unit[t]), 2'(t_mode[t]), 3'(t_div[t]), 1'(t_en[t])};
    repeat (3) @(negedge clk);
    check("R1 in reset", result, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after reset", result, 32'h0);

    for (int ch = 0; ch < NCH; ch++) begin
      run(NCH'(1) << ch, ch, 5, 9);
      run(NCH'(1) << ch, ch, 13, 7);
      run(NCH'(1) << ch, ch, 90, 110);
    end

    // R2: two bits rise together, channel 3 (rising, div 0) wins over 5
    run((NCH'(1) << 3) | (NCH'(1) << 5), 3, 11, 6);

    // R2: trigger bit held high, further edges must not restart
    held = result;
    for (int k = 0; k < 4; k++) begin
      tach[3] = ~tach[3];
      repeat (6) @(negedge clk);
    end
    tach[5] = 1'b0;
    repeat (6) @(negedge clk);
    check("R2 held trigger", result, held);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule